// File: doc/BRIEF.md
# Hidden Address-Pointer Tracker

This block keeps the hidden 16-bit pointer that an 8-bit CPU core of the classic register-pair family updates alongside its visible registers. The core never reads this pointer through a normal instruction. It matters because some undocumented flag bits are taken from it, and a faithful core has to reproduce its value after every instruction.

The surrounding decoder presents a one-cycle strobe together with an instruction-class code. On the same cycle it presents every operand the update rules might need: the three register pairs, the fetched immediate word, the word popped from the stack, the program counter, the relative-branch offset with its taken flag, the restart vector and the accumulator byte being stored. On the next rising clock edge the block works out the new pointer value for that class and registers it. Classes with no rule leave the pointer as it is.

Top module: `hptr_track`

## Requirements
- R1: A synchronous active-high `rst` clears `ptr_out` to 0x0000 at the next rising edge. Every update appears on `ptr_out` one clock edge after the strobe cycle.
- R2: When `op_valid` is low, the pointer holds its value whatever the other inputs are. With `op_valid` high, class code 0 (no rule) and codes 17 to 31 also hold it.
- R3: Byte loads of the accumulator set the pointer to the address plus one. Code 1 uses `pair_bc`, code 2 uses `pair_de` and code 3 uses `imm_word`.
- R4: Byte stores of the accumulator set the pointer's upper byte to `acc_val`. Its lower byte becomes the lower byte of (address + 1), so no carry reaches the upper byte. Code 4 uses `pair_bc`, code 5 uses `pair_de` and code 6 uses `imm_word`.
- R5: A 16-bit load or store through an immediate address (code 7) sets the pointer to `imm_word` + 1.
- R6: An absolute jump (code 8) or a call (code 9) sets the pointer to `imm_word`. The decoder strobes these codes whether or not the branch condition holds.
- R7: A return (code 10) sets the pointer to `pop_word`. This is the value the program counter is loaded with.
- R8: A restart (code 11) sets the pointer's lower byte to `rst_vec` and its upper byte to zero.
- R9: A relative branch (code 12) with `rel_taken` high sets the pointer to `cur_pc` plus the sign-extended `rel_off`. With `rel_taken` low the pointer holds its value.
- R10: Port input or output through `pair_bc` (code 13) and the incrementing block input (code 14) set the pointer to `pair_bc` + 1. The decrementing block input (code 15) sets it to `pair_bc` − 1.
- R11: The nibble-rotate instructions (code 16) set the pointer to `pair_hl` + 1.
- R12: All pointer arithmetic wraps modulo 2^16. For example, 0xFFFF + 1 gives 0x0000 and 0x0000 − 1 gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle strobe: an instruction class is present |
| op_class | input | 5 | Instruction-class code (see requirements) |
| pair_bc | input | 16 | BC register pair |
| pair_de | input | 16 | DE register pair |
| pair_hl | input | 16 | HL register pair |
| imm_word | input | 16 | Fetched 16-bit immediate operand |
| pop_word | input | 16 | Word popped from the stack for a return |
| cur_pc | input | 16 | Program counter after the operand fetch |
| rel_off | input | 8 | Signed relative-branch offset |
| rel_taken | input | 1 | Relative branch condition is true |
| rst_vec | input | 8 | Restart vector |
| acc_val | input | 8 | Accumulator byte being stored |
| ptr_out | output | 16 | Registered hidden pointer value |

## Verification
The hardest cases to reach are the ones where the pointer must not change or must not carry. These are an untaken relative branch, a strobe-low cycle while valid-looking operands are present, and a byte store whose address has 0xFF in its lower byte, where the increment must stop at the lower byte. Random operands seldom hit these situations with a known prior value, so directed steps set up a distinct pointer first. They then apply the hold or carry case and read the pointer back at the port. The random phase mixes all 32 class codes, including the unused ones. It also drops the strobe about one cycle in ten and randomises the branch flag, so each hold path is also reached from arbitrary earlier states.

// File: rtl/hptr_pkg.sv
package hptr_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NONE       = 5'd0,
    OP_LDA_BC     = 5'd1,
    OP_LDA_DE     = 5'd2,
    OP_LDA_IMM    = 5'd3,
    OP_STA_BC     = 5'd4,
    OP_STA_DE     = 5'd5,
    OP_STA_IMM    = 5'd6,
    OP_WORD_IMM   = 5'd7,
    OP_JUMP       = 5'd8,
    OP_CALL       = 5'd9,
    OP_RET        = 5'd10,
    OP_RESTART    = 5'd11,
    OP_JREL       = 5'd12,
    OP_PORT_IO    = 5'd13,
    OP_BLKIN_INC  = 5'd14,
    OP_BLKIN_DEC  = 5'd15,
    OP_NIB_ROT    = 5'd16
  } hptr_op_e;

  typedef enum logic [1:0] {
    ADJ_NONE = 2'd0,
    ADJ_INC  = 2'd1,
    ADJ_DEC  = 2'd2,
    ADJ_REL  = 2'd3
  } hptr_adj_e;

endpackage

// File: rtl/hptr_src_sel.sv
module hptr_src_sel #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [hptr_pkg::OP_W-1:0] op_class,
  input  logic                      rel_taken,
  input  logic [AW-1:0]             pair_bc,
  input  logic [AW-1:0]             pair_de,
  input  logic [AW-1:0]             pair_hl,
  input  logic [AW-1:0]             imm_word,
  input  logic [AW-1:0]             pop_word,
  input  logic [AW-1:0]             cur_pc,
  input  logic [DW-1:0]             rst_vec,
  output logic [AW-1:0]             base,
  output hptr_pkg::hptr_adj_e       adj,
  output logic                      hi_sub,
  output logic                      upd
);
  import hptr_pkg::*;

  localparam int PAD = AW - DW;

  always_comb begin
    base   = '0;
    adj    = ADJ_NONE;
    hi_sub = 1'b0;
    upd    = 1'b1;
    case (hptr_op_e'(op_class))
      OP_LDA_BC:    begin base = pair_bc;  adj = ADJ_INC; end
      OP_LDA_DE:    begin base = pair_de;  adj = ADJ_INC; end
      OP_LDA_IMM:   begin base = imm_word; adj = ADJ_INC; end
      OP_STA_BC:    begin base = pair_bc;  adj = ADJ_INC; hi_sub = 1'b1; end
      OP_STA_DE:    begin base = pair_de;  adj = ADJ_INC; hi_sub = 1'b1; end
      OP_STA_IMM:   begin base = imm_word; adj = ADJ_INC; hi_sub = 1'b1; end
      OP_WORD_IMM:  begin base = imm_word; adj = ADJ_INC; end
      OP_JUMP:      begin base = imm_word; end
      OP_CALL:      begin base = imm_word; end
      OP_RET:       begin base = pop_word; end
      OP_RESTART:   begin base = {{PAD{1'b0}}, rst_vec}; end
      OP_JREL:      begin base = cur_pc; adj = ADJ_REL; upd = rel_taken; end
      OP_PORT_IO:   begin base = pair_bc; adj = ADJ_INC; end
      OP_BLKIN_INC: begin base = pair_bc; adj = ADJ_INC; end
      OP_BLKIN_DEC: begin base = pair_bc; adj = ADJ_DEC; end
      OP_NIB_ROT:   begin base = pair_hl; adj = ADJ_INC; end
      default:      begin upd = 1'b0; end
    endcase
  end

endmodule

// File: rtl/hptr_step.sv
module hptr_step #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0]       base,
  input  hptr_pkg::hptr_adj_e adj,
  input  logic [DW-1:0]       rel_off,
  output logic [AW-1:0]       sum
);
  import hptr_pkg::*;

  localparam int PAD = AW - DW;

  logic [AW-1:0] rel_ext;

  generate
    if (PAD > 0) begin : g_sext
      assign rel_ext = {{PAD{rel_off[DW-1]}}, rel_off};
    end else begin : g_nosext
      assign rel_ext = rel_off[AW-1:0];
    end
  endgenerate

  always_comb begin
    case (adj)
      ADJ_INC: sum = base + AW'(1);
      ADJ_DEC: sum = base - AW'(1);
      ADJ_REL: sum = base + rel_ext;
      default: sum = base;
    endcase
  end

endmodule

// File: rtl/hptr_compose.sv
module hptr_compose #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] sum,
  input  logic          hi_sub,
  input  logic [DW-1:0] acc_val,
  output logic [AW-1:0] next_val
);
  localparam int LO = AW - DW;

  always_comb begin
    if (hi_sub) next_val = {acc_val, sum[LO-1:0]};
    else        next_val = sum;
  end

endmodule

// File: rtl/hptr_track.sv
module hptr_track #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      op_valid,
  input  logic [hptr_pkg::OP_W-1:0] op_class,
  input  logic [AW-1:0]             pair_bc,
  input  logic [AW-1:0]             pair_de,
  input  logic [AW-1:0]             pair_hl,
  input  logic [AW-1:0]             imm_word,
  input  logic [AW-1:0]             pop_word,
  input  logic [AW-1:0]             cur_pc,
  input  logic [DW-1:0]             rel_off,
  input  logic                      rel_taken,
  input  logic [DW-1:0]             rst_vec,
  input  logic [DW-1:0]             acc_val,
  output logic [AW-1:0]             ptr_out
);
  import hptr_pkg::*;

  logic [AW-1:0] base;
  hptr_adj_e     adj;
  logic          hi_sub;
  logic          upd;
  logic [AW-1:0] sum;
  logic [AW-1:0] next_val;
  logic [AW-1:0] ptr_q;

  hptr_src_sel #(.AW(AW), .DW(DW)) u_sel (
    .op_class (op_class),
    .rel_taken(rel_taken),
    .pair_bc  (pair_bc),
    .pair_de  (pair_de),
    .pair_hl  (pair_hl),
    .imm_word (imm_word),
    .pop_word (pop_word),
    .cur_pc   (cur_pc),
    .rst_vec  (rst_vec),
    .base     (base),
    .adj      (adj),
    .hi_sub   (hi_sub),
    .upd      (upd)
  );

  hptr_step #(.AW(AW), .DW(DW)) u_step (
    .base   (base),
    .adj    (adj),
    .rel_off(rel_off),
    .sum    (sum)
  );

  hptr_compose #(.AW(AW), .DW(DW)) u_comp (
    .sum     (sum),
    .hi_sub  (hi_sub),
    .acc_val (acc_val),
    .next_val(next_val)
  );

  always_ff @(posedge clk) begin
    if (rst)                  ptr_q <= '0;
    else if (op_valid && upd) ptr_q <= next_val;
  end

  assign ptr_out = ptr_q;

endmodule

// File: rtl/hptr_track_chk.sv
module hptr_track_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      op_valid,
  input logic [hptr_pkg::OP_W-1:0] op_class,
  input logic [AW-1:0]             pair_bc,
  input logic [AW-1:0]             imm_word,
  input logic [DW-1:0]             rel_off,
  input logic                      rel_taken,
  input logic [DW-1:0]             rst_vec,
  input logic [DW-1:0]             acc_val,
  input logic [AW-1:0]             ptr_out
);
  import hptr_pkg::*;

  localparam int LO = AW - DW;

  logic unused_ok;
  assign unused_ok = ^rel_off;

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> (ptr_out == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(ptr_out));

  // R4
  store_mix_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class == OP_STA_BC) |=>
      (ptr_out[AW-1:LO] == $past(acc_val)) &&
      (ptr_out[LO-1:0] == LO'($past(pair_bc[LO-1:0]) + LO'(1))));

  // R6
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_class == OP_JUMP || op_class == OP_CALL)) |=>
      (ptr_out == $past(imm_word)));

  // R8
  restart_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class == OP_RESTART) |=>
      (ptr_out == {{LO{1'b0}}, $past(rst_vec)}));

  // R9
  rel_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class == OP_JREL && !rel_taken) |=> $stable(ptr_out));

  // R10
  blk_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class == OP_BLKIN_DEC) |=>
      (ptr_out == AW'($past(pair_bc) - AW'(1))));

endmodule

bind hptr_track hptr_track_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .op_class (op_class),
  .pair_bc  (pair_bc),
  .imm_word (imm_word),
  .rel_off  (rel_off),
  .rel_taken(rel_taken),
  .rst_vec  (rst_vec),
  .acc_val  (acc_val),
  .ptr_out  (ptr_out)
);

// File: tb/hptr_track_bench.sv
`timescale 1ns/1ps
module hptr_track_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [4:0]  op_class = 5'd0;
  logic [15:0] pair_bc = '0, pair_de = '0, pair_hl = '0;
  logic [15:0] imm_word = '0, pop_word = '0, cur_pc = '0;
  logic [7:0]  rel_off = '0, rst_vec = '0, acc_val = '0;
  logic        rel_taken = 1'b0;
  logic [15:0] ptr_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] model = '0;

  always #2 clk = ~clk;

  hptr_track u_hptr_track (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_class(op_class),
    .pair_bc(pair_bc), .pair_de(pair_de), .pair_hl(pair_hl),
    .imm_word(imm_word), .pop_word(pop_word), .cur_pc(cur_pc),
    .rel_off(rel_off), .rel_taken(rel_taken), .rst_vec(rst_vec),
    .acc_val(acc_val), .ptr_out(ptr_out)
  );

  function automatic string req_of(input logic v, input logic [4:0] c);
    if (!v) return "R2";
    case (c)
      5'd1, 5'd2, 5'd3:   return "R3";
      5'd4, 5'd5, 5'd6:   return "R4";
      5'd7:               return "R5";
      5'd8, 5'd9:         return "R6";
      5'd10:              return "R7";
      5'd11:              return "R8";
      5'd12:              return "R9";
      5'd13, 5'd14, 5'd15: return "R10";
      5'd16:              return "R11";
      default:            return "R2";
    endcase
  endfunction

  function automatic logic [15:0] expect_ptr(input logic [15:0] prev);
    logic [15:0] a;
    if (!op_valid) return prev;
    case (op_class)
      5'd1: return pair_bc + 16'd1;
      5'd2: return pair_de + 16'd1;
      5'd3: return imm_word + 16'd1;
      5'd4: begin a = pair_bc + 16'd1;  return {acc_val, a[7:0]}; end
      5'd5: begin a = pair_de + 16'd1;  return {acc_val, a[7:0]}; end
      5'd6: begin a = imm_word + 16'd1; return {acc_val, a[7:0]}; end
      5'd7: return imm_word + 16'd1;
      5'd8, 5'd9: return imm_word;
      5'd10: return pop_word;
      5'd11: return {8'h00, rst_vec};
      5'd12: return rel_taken ? cur_pc + {{8{rel_off[7]}}, rel_off} : prev;
      5'd13, 5'd14: return pair_bc + 16'd1;
      5'd15: return pair_bc - 16'd1;
      5'd16: return pair_hl + 16'd1;
      default: return prev;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    n_chk++;
    if (ptr_out !== exp) begin
      n_fail++;
      $display("FAIL %s: ptr_out=%h expected=%h", req, ptr_out, exp);
    end
  endtask

  task automatic step(input string tag);
    string req;
    req = (tag == "") ? req_of(op_valid, op_class) : tag;
    model = expect_ptr(model);
    @(posedge clk); #1;
    check(req, model);
    @(negedge clk);
  endtask

  task automatic setop(input logic v, input logic [4:0] c);
    op_valid = v; op_class = c;
  endtask

  task automatic randomize_ops();
    pair_bc = 16'($urandom); pair_de = 16'($urandom); pair_hl = 16'($urandom);
    imm_word = 16'($urandom); pop_word = 16'($urandom); cur_pc = 16'($urandom);
    rel_off = 8'($urandom); rst_vec = 8'($urandom); acc_val = 8'($urandom);
    rel_taken = 1'($urandom);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: ptr_out=%h expected=completion", ptr_out);
    summary();
  end

  initial begin
    void'($urandom(32'd7351));
    repeat (3) @(posedge clk);
    #1; check("R1", 16'h0000);
    @(negedge clk); rst = 1'b0;

    // R12 wrap on increment
    setop(1, 5'd1); pair_bc = 16'hFFFF; step("R12");
    // R12 wrap on decrement
    setop(1, 5'd15); pair_bc = 16'h0000; step("R12");
    // R4 no carry into upper byte
    setop(1, 5'd4); pair_bc = 16'h12FF; acc_val = 8'hA5; step("R4");
    // R9 negative offset
    setop(1, 5'd12); cur_pc = 16'h0005; rel_off = 8'h80; rel_taken = 1; step("R9");
    // R9 untaken holds after distinct value
    setop(1, 5'd8); imm_word = 16'hBEEF; step("R6");
    setop(1, 5'd12); cur_pc = 16'h1000; rel_off = 8'h10; rel_taken = 0; step("R9");
    // R2 strobe low with a loading class
    setop(0, 5'd8); imm_word = 16'h4321; step("R2");
    // R2 unused code
    setop(1, 5'd23); step("R2");
    // R8 restart
    setop(1, 5'd11); rst_vec = 8'h38; step("R8");
    // R7 return
    setop(1, 5'd10); pop_word = 16'h8001; step("R7");
    // R11 nibble rotate
    setop(1, 5'd16); pair_hl = 16'h00FF; step("R11");
    // R5 word via immediate
    setop(1, 5'd7); imm_word = 16'hFFFF; step("R5");
    // R10 port i/o
    setop(1, 5'd13); pair_bc = 16'h7FFF; step("R10");

    for (int i = 0; i < 4000; i++) begin
      randomize_ops();
      setop($urandom_range(0, 9) != 0, 5'($urandom_range(0, 31)));
      step("");
    end

    // R1 reset mid-run
    setop(1, 5'd8); imm_word = 16'h5A5A; step("R6");
    rst = 1'b1; setop(0, 5'd0);
    @(posedge clk); #1; check("R1", 16'h0000);
    summary();
  end

endmodule